// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter. While it is idle it holds the sample-and-hold in its sampling phase. A one-cycle write pulse on the GO control starts a conversion. Sampling stops at once. The block waits a start delay and then runs twelve periods of a conversion clock. The first ten periods decide the result bits from the most significant bit down, by driving a trial code to an external DAC and reading back an external comparator.

The conversion clock comes from one of two sources. It can be the system clock divided by 2, 4 or 8, or it can be pulses on an RC-source enable input. The source is selected by a 2-bit field, which is captured when the conversion starts. The RC source adds one instruction cycle to the start delay. When the twelfth period ends, four things happen on the same clock edge: the result register changes from the previous value to the new one, GO clears, the sticky done flag sets, and sampling resumes. Software can read the new result on the next cycle.

Top module: `sar_seq`

## Requirements
- R1: After reset, go, done_flag, result and dac_code are 0, and sample_en is 1.
- R2: While go is 0, a go_set pulse makes go read 1 on the next cycle, and sample_en falls on that same edge. sample_en is the inverse of go at all times.
- R3: With clk_sel 0, 1 or 2, the conversion clock is the system clock divided by 2, 4 or 8 respectively. go stays high for exactly 1 + 12·N cycles, where N is the divide ratio.
- R4: With clk_sel 3, conversion periods are counted on cycles where rc_tick is 1. The start delay grows by INSTR_CYC (4) cycles. With rc_tick held at 1, go stays high for exactly 17 cycles.
- R5: The result bits are decided from bit 9 down to bit 0, one per conversion period. Each trial sets the bit under test in dac_code. The bit is kept when cmp_hi is 1, meaning the input is at or above the trial level, and cleared otherwise. With an ideal comparator, the result equals the input code.
- R6: result keeps its previous value throughout a conversion. It changes only on the edge where go falls, which is also the edge where done_flag sets and sample_en rises.
- R7: A go_set pulse while go is 1 has no effect on the conversion or on its timing.
- R8: done_flag stays set until flag_clr is high. If a clear and a completion fall on the same cycle, done_flag ends up set. done_flag rises only on a completion.
- R9: Changing clk_sel during a conversion does not change that conversion's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_set | input | 1 | Write pulse that starts a conversion |
| clk_sel | input | 2 | Conversion clock source: 0/1/2 = divide by 2/4/8, 3 = RC source |
| rc_tick | input | 1 | RC-source conversion clock enable |
| flag_clr | input | 1 | Clears the done flag |
| cmp_hi | input | 1 | Comparator: input at or above trial level |
| go | output | 1 | Conversion in progress (GO bit) |
| done_flag | output | 1 | Sticky conversion-done flag |
| result | output | 10 | Result register |
| dac_code | output | 10 | Trial code driven to the DAC |
| sample_en | output | 1 | Sample-and-hold sampling enable |

## Verification
The bound checker watches the following on every cycle: the link between sample_en and go, go rising on an accepted start, result staying fixed until go falls, done_flag staying set until it is cleared, and done_flag rising only when go falls. It also checks that the first trial code is the mid-scale value. Cycle-exact conversion lengths for each clock source and the extra RC start delay can only be shown by the bench's scenarios. The same holds for correct result values over a range of input codes, for go_set being ignored while busy, and for clk_sel being captured at the start. For those, a behavioural model is compared with the outputs every cycle.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W          = 10,
  parameter int INSTR_CYC  = 4,
  parameter int CONV_TICKS = 12,
  parameter int SELW       = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_set,
  input  logic [SELW-1:0] clk_sel,
  input  logic         rc_tick,
  input  logic         flag_clr,
  input  logic         cmp_hi,
  output logic         go,
  output logic         done_flag,
  output logic [W-1:0] result,
  output logic [W-1:0] dac_code,
  output logic         sample_en
);
  localparam int MAXDIV = 2 << ((1 << SELW) - 2);
  localparam int VW = $clog2(MAXDIV);
  localparam int TW = $clog2(CONV_TICKS + 1);
  localparam int DW = $clog2(INSTR_CYC + 1);
  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CONV} st_t;
  st_t st;

  logic [SELW-1:0] sel_q;
  logic [DW-1:0]   dly;
  logic [VW-1:0]   divcnt;
  logic [TW-1:0]   tcnt;
  logic [W-1:0]    code, mask;
  logic [VW:0]     div_n;

  assign div_n = (VW+1)'(2) << sel_q;

  wire rc_mode  = &sel_q;
  wire tick     = (st == S_CONV) & (rc_mode ? rc_tick : ({1'b0, divcnt} == div_n - 1'b1));
  wire deciding = tick & (tcnt < TW'(W));
  wire last     = tick & (tcnt == TW'(CONV_TICKS - 1));

  assign sample_en = (st == S_IDLE);
  assign dac_code  = code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sel_q <= '0;
      dly <= '0;
      divcnt <= '0;
      tcnt <= '0;
      code <= '0;
      mask <= '0;
      result <= '0;
      go <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      done_flag <= (done_flag & ~flag_clr) | last;
      case (st)
        S_IDLE: if (go_set) begin
          st <= S_WAIT;
          go <= 1'b1;
          sel_q <= clk_sel;
          dly <= (&clk_sel) ? DW'(INSTR_CYC) : '0;
        end
        S_WAIT: if (dly == '0) begin
          st <= S_CONV;
          divcnt <= '0;
          tcnt <= '0;
          code <= MSB;
          mask <= MSB;
        end else begin
          dly <= dly - 1'b1;
        end
        S_CONV: begin
          divcnt <= tick ? '0 : divcnt + 1'b1;
          if (tick) tcnt <= tcnt + 1'b1;
          if (deciding) begin
            code <= (cmp_hi ? code : (code & ~mask)) | (mask >> 1);
            mask <= mask >> 1;
          end
          if (last) begin
            result <= code;
            go <= 1'b0;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go_set,
  input logic         flag_clr,
  input logic         go,
  input logic         done_flag,
  input logic [W-1:0] result,
  input logic [W-1:0] dac_code,
  input logic         sample_en
);
  AST_SAMPLE_INV: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en == !go);                                                   // R2
  AST_GO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && go_set) |=> go);                                             // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ($stable(result) || !go));                                    // R6
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> done_flag);                                            // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);                             // R8
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(go));                                     // R8
  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $changed(dac_code) && $past(go) && $past(dac_code) == '0) |-> dac_code == {1'b1, {(W-1){1'b0}}}); // R5
endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_set(go_set), .flag_clr(flag_clr),
  .go(go), .done_flag(done_flag), .result(result),
  .dac_code(dac_code), .sample_en(sample_en)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go_set = 1'b0, rc_tick = 1'b0, flag_clr = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic go, done_flag, sample_en, cmp_hi;
  logic [9:0] result, dac_code;
  int vin = 0;
  int total = 0, bad = 0, cyc = 0;
  int rc_period = 3;
  bit finished = 0;

  // ideal comparator: input at or above trial level
  assign cmp_hi = (vin >= int'(dac_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_seq u_sar_seq (
    .clk(clk), .rst_n(rst_n), .go_set(go_set), .clk_sel(clk_sel),
    .rc_tick(rc_tick), .flag_clr(flag_clr), .cmp_hi(cmp_hi),
    .go(go), .done_flag(done_flag), .result(result),
    .dac_code(dac_code), .sample_en(sample_en)
  );

  // behavioural reference model
  bit m_busy = 0, m_flag = 0;
  int m_res = 0, m_wait = 0, m_ph = 0, m_ticks = 0, m_sel = 0;

  always @(posedge clk) begin
    bit done, tk;
    done = 0;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_flag = 0; m_res = 0;
    end else begin
      if (!m_busy) begin
        if (go_set) begin
          m_busy = 1; m_sel = clk_sel;
          m_wait = 1 + (clk_sel == 3 ? 4 : 0);
          m_ph = 0; m_ticks = 0;
        end
      end else if (m_wait > 0) begin
        m_wait--;
      end else begin
        if (m_sel == 3) tk = rc_tick;
        else begin
          m_ph++;
          tk = (m_ph == (2 << m_sel));
          if (tk) m_ph = 0;
        end
        if (tk) begin
          m_ticks++;
          if (m_ticks == 12) begin
            done = 1; m_busy = 0; m_res = vin;
          end
        end
      end
      m_flag = (m_flag && !flag_clr) || done;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(go == m_busy, "R2/R7 go", go, m_busy);
      chk(sample_en == !m_busy, "R2 sample_en", sample_en, !m_busy);
      chk(done_flag == m_flag, "R8 done_flag", done_flag, m_flag);
      chk(int'(result) == m_res, "R5/R6 result", result, m_res);
    end
    rc_tick <= (rc_period > 0) && (cyc % rc_period == 0);
  end

  task automatic run_conv(input int sel, input int v, input int exp_len, input string req);
    int n;
    @(negedge clk);
    clk_sel = 2'(sel); vin = v; go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    n = 0;
    while (go) begin @(negedge clk); n++; end
    if (exp_len > 0) chk(n == exp_len, req, n, exp_len);
    chk(int'(result) == v, "R5 result value", result, v);
    chk(done_flag == 1'b1, "R6 flag at done", done_flag, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(go == 0 && done_flag == 0 && result == 0 && dac_code == 0 && sample_en == 1,
        "R1 reset state", {go, done_flag, sample_en}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 divider sources
    run_conv(0, 677, 25, "R3 div2 length");
    run_conv(1, 0, 49, "R3 div4 length");
    run_conv(2, 1023, 97, "R3 div8 length");
    // R4 RC source, tick every cycle then sparse ticks
    rc_period = 1;
    run_conv(3, 512, 17, "R4 rc length");
    rc_period = 3;
    run_conv(3, 511, 0, "R4 rc sparse");
    // R5 several codes
    for (int i = 0; i < 6; i++) run_conv(0, (i * 173 + 41) % 1024, 25, "R5 code sweep");
    // R7 go_set while busy
    @(negedge clk);
    clk_sel = 2'd1; vin = 300; go_set = 1'b1;
    @(negedge clk); go_set = 1'b0;
    repeat (10) @(negedge clk);
    go_set = 1'b1; @(negedge clk); go_set = 1'b0;
    // R9 select change mid conversion
    clk_sel = 2'd2;
    while (go) @(negedge clk);
    chk(int'(result) == 300, "R7 result after ignored go", result, 300);
    // R8 clear held through completion: set wins
    @(negedge clk);
    flag_clr = 1'b1; clk_sel = 2'd0; vin = 88; go_set = 1'b1;
    @(negedge clk); go_set = 1'b0;
    while (go) @(negedge clk);
    chk(done_flag == 1'b1, "R8 set beats clear", done_flag, 1);
    @(negedge clk);
    chk(done_flag == 1'b0, "R8 clear next cycle", done_flag, 0);
    flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule